// File: doc/BRIEF.md
# Crank Stall Resynchronization Controller

This block sequences the engine-angle counter used by crank-driven timing logic. Crank-tooth strobes walk a small state machine through three phases before it reaches synchronized running. First it searches for the tooth pattern. Then it passes over a run of blank teeth. Then it waits for the first transition, which marks the start of synchronized operation. A free-running angle counter advances on a tick enable. It is cleared at the points where the pattern locks and where synchronization begins.

When a stall strobe arrives, the controller recovers without a full restart. The angle counter is zeroed only when its value lies in the lower half of the unsigned range. A counter in the upper half is left alone, so that pending greater-or-equal compares in dependent channels do not all fall into the past at once. The engine-cycle start register is loaded with the cycle-length input rather than zero, which places the first compare window one full cycle ahead. A one-cycle re-initialize strobe tells the dependent channels to restart. The machine then goes straight to the first-transition state, skipping the search and blank-teeth phases for a quick resync, and the next tooth zeroes the counter.

Top module: `crank_resync_ctrl`

## Requirements
- R1: After reset, state_o is 0 (search), angle_o is 0, cyc_start_o is 0 and reinit_o is 0.
- R2: The state encodings are search=0, blank=1, first-transition=2 and synced=3. In search, the SEARCH_TEETH-th tooth moves the machine to blank and clears angle_o. In blank, the BLANK_TEETH-th tooth moves it to first-transition. In first-transition, the next tooth moves it to synced and clears angle_o.
- R3: With no stall and no clearing tooth, each cycle with tick_i high raises angle_o by one, and a cycle with tick_i low holds it.
- R4: A stall strobe moves the machine to first-transition from any state, and it takes priority over a tooth in the same cycle.
- R5: On a stall, angle_o becomes 0 when its unsigned value is below 2^(CNT_W-1). For the default CNT_W of 24, that threshold is 0x800000.
- R6: On a stall with angle_o at or above 2^(CNT_W-1), angle_o is held unchanged, even when tick_i is high in the same cycle.
- R7: On a stall, cyc_start_o is loaded with the value of cyc_len_i. It keeps that value until the next stall.
- R8: reinit_o is high for exactly the one cycle that follows the clock edge at which the stall was taken, and it is low otherwise.
- R9: In the synced state, teeth change neither the state nor angle_o.
- R10: angle_o wraps from 2^CNT_W-1 to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Angle-counter advance enable |
| tooth_i | input | 1 | Crank tooth strobe |
| stall_i | input | 1 | Stall detected strobe |
| cyc_len_i | input | CNT_W | Angle ticks per engine cycle |
| angle_o | output | CNT_W | Engine-angle counter |
| cyc_start_o | output | CNT_W | Engine-cycle start value |
| reinit_o | output | 1 | Re-initialize strobe for dependent channels |
| state_o | output | 2 | Synchronization state |

## Verification
Two collisions matter most. A stall can coincide with a tooth, and a stall can coincide with a tick. The bench drives the stall and the tooth in the same cycle while the machine is in search. A tooth would normally move it to blank, so the only passing result is the first-transition state with a cleared counter. The bench also drives the stall and the tick together with the counter exactly one below and exactly at the half-range boundary. It expects a zero in the first case and the unchanged, non-incremented value in the second.

// File: rtl/crank_resync_pkg.sv
package crank_resync_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_BLANK  = 2'd1,
    ST_FIRST  = 2'd2,
    ST_SYNCED = 2'd3
  } sync_state_e;
endpackage

// File: rtl/crank_seq_fsm.sv
module crank_seq_fsm
  import crank_resync_pkg::*;
#(
  parameter int SEARCH_TEETH = 3,
  parameter int BLANK_TEETH  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tooth_i,
  input  logic        stall_i,
  output sync_state_e state_o,
  output logic        tooth_clr_o
);
  localparam int MAX_TEETH = (SEARCH_TEETH > BLANK_TEETH) ? SEARCH_TEETH : BLANK_TEETH;
  localparam int TCNT_W    = $clog2(MAX_TEETH + 1);
  localparam logic [TCNT_W-1:0] SEARCH_LAST = TCNT_W'(SEARCH_TEETH - 1);
  localparam logic [TCNT_W-1:0] BLANK_LAST  = TCNT_W'(BLANK_TEETH - 1);

  sync_state_e       state_q, state_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic              state_en, tcnt_en;

  always_comb begin
    state_d     = state_q;
    tcnt_d      = tcnt_q;
    tooth_clr_o = 1'b0;
    if (stall_i) begin
      state_d = ST_FIRST;
      tcnt_d  = '0;
    end else if (tooth_i) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (tcnt_q == SEARCH_LAST) begin
            state_d     = ST_BLANK;
            tcnt_d      = '0;
            tooth_clr_o = 1'b1;
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
        ST_BLANK: begin
          if (tcnt_q == BLANK_LAST) begin
            state_d = ST_FIRST;
            tcnt_d  = '0;
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
        ST_FIRST: begin
          state_d     = ST_SYNCED;
          tooth_clr_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_en = stall_i | tooth_i;
  assign tcnt_en  = stall_i | tooth_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      tcnt_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (tcnt_en)  tcnt_q  <= tcnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/crank_angle_cnt.sv
module crank_angle_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             stall_i,
  input  logic             tooth_clr_i,
  output logic [CNT_W-1:0] angle_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             upper_half;

  assign upper_half = cnt_q[CNT_W-1];

  always_comb begin
    cnt_d = cnt_q;
    if (stall_i) begin
      if (!upper_half) cnt_d = '0;
    end else if (tooth_clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign cnt_en = stall_i | tooth_clr_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign angle_o = cnt_q;
endmodule

// File: rtl/crank_stall_regs.sv
module crank_stall_regs #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic [CNT_W-1:0] cyc_len_i,
  output logic [CNT_W-1:0] cyc_start_o,
  output logic             reinit_o
);
  logic [CNT_W-1:0] start_q;
  logic             reinit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_q <= '0;
    else if (stall_i) start_q <= cyc_len_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reinit_q <= 1'b0;
    else        reinit_q <= stall_i;
  end

  assign cyc_start_o = start_q;
  assign reinit_o    = reinit_q;
endmodule

// File: rtl/crank_resync_ctrl.sv
module crank_resync_ctrl
  import crank_resync_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int SEARCH_TEETH = 3,
  parameter int BLANK_TEETH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             tooth_i,
  input  logic             stall_i,
  input  logic [CNT_W-1:0] cyc_len_i,
  output logic [CNT_W-1:0] angle_o,
  output logic [CNT_W-1:0] cyc_start_o,
  output logic             reinit_o,
  output logic [1:0]       state_o
);
  logic        rst_meta_n, rst_sync_n;
  sync_state_e state;
  logic        tooth_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  crank_seq_fsm #(
    .SEARCH_TEETH(SEARCH_TEETH),
    .BLANK_TEETH (BLANK_TEETH)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tooth_i    (tooth_i),
    .stall_i    (stall_i),
    .state_o    (state),
    .tooth_clr_o(tooth_clr)
  );

  crank_angle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .stall_i    (stall_i),
    .tooth_clr_i(tooth_clr),
    .angle_o    (angle_o)
  );

  crank_stall_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stall_i    (stall_i),
    .cyc_len_i  (cyc_len_i),
    .cyc_start_o(cyc_start_o),
    .reinit_o   (reinit_o)
  );

  assign state_o = state;
endmodule

// File: rtl/crank_resync_checker.sv
module crank_resync_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             tooth_i,
  input logic             stall_i,
  input logic [CNT_W-1:0] cyc_len_i,
  input logic [CNT_W-1:0] angle_o,
  input logic [CNT_W-1:0] cyc_start_o,
  input logic             reinit_o,
  input logic [1:0]       state_o
);
  p_stall_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> state_o == 2'd2);

  p_low_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !angle_o[CNT_W-1]) |=> angle_o == '0);

  p_high_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && angle_o[CNT_W-1]) |=> $stable(angle_o));

  p_start_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> cyc_start_o == $past(cyc_len_i));

  p_start_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> $stable(cyc_start_o));

  p_reinit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> reinit_o);

  p_reinit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> !reinit_o);

  p_first_tooth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && tooth_i && !stall_i) |=> (state_o == 2'd3 && angle_o == '0));

  p_synced_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !stall_i) |=> state_o == 2'd3);

  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && tick_i && !stall_i) |=> angle_o == $past(angle_o) + CNT_W'(1));
endmodule

bind crank_resync_ctrl crank_resync_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick_i     (tick_i),
  .tooth_i    (tooth_i),
  .stall_i    (stall_i),
  .cyc_len_i  (cyc_len_i),
  .angle_o    (angle_o),
  .cyc_start_o(cyc_start_o),
  .reinit_o   (reinit_o),
  .state_o    (state_o)
);

// File: tb/crank_resync_ctrl_tb.sv
`timescale 1ns/1ps
module crank_resync_ctrl_tb;
  localparam int W    = 10;
  localparam int HALF = 1 << (W - 1);
  localparam int FULL = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         tick_i, tooth_i, stall_i;
  logic [W-1:0] cyc_len_i;
  logic [W-1:0] angle_o, cyc_start_o;
  logic         reinit_o;
  logic [1:0]   state_o;

  int n_vec;
  int n_bad;
  int cycles;

  crank_resync_ctrl #(.CNT_W(W), .SEARCH_TEETH(3), .BLANK_TEETH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tooth_i(tooth_i),
    .stall_i(stall_i), .cyc_len_i(cyc_len_i), .angle_o(angle_o),
    .cyc_start_o(cyc_start_o), .reinit_o(reinit_o), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic s, input logic k);
    tooth_i = t; stall_i = s; tick_i = k;
    @(posedge clk);
    #2;
    tooth_i = 1'b0; stall_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic do_reset();
    tooth_i = 1'b0; stall_i = 1'b0; tick_i = 1'b0; cyc_len_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic to_synced();
    do_reset();
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "state", state_o, 0);
    chk("R1", "angle", angle_o, 0);
    chk("R1", "start", cyc_start_o, 0);
    chk("R1", "reinit", reinit_o, 0);
  endtask

  task automatic t_sequence();
    do_reset();
    ticks(5);
    chk("R3", "angle after 5 ticks", angle_o, 5);
    step(1'b0, 1'b0, 1'b0);
    chk("R3", "angle hold no tick", angle_o, 5);
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    chk("R2", "still search", state_o, 0);
    chk("R2", "angle kept in search", angle_o, 5);
    step(1'b1, 1'b0, 1'b1);
    chk("R2", "to blank", state_o, 1);
    chk("R2", "cleared at lock", angle_o, 0);
    ticks(3);
    step(1'b1, 1'b0, 1'b0);
    chk("R2", "blank after one tooth", state_o, 1);
    step(1'b1, 1'b0, 1'b0);
    chk("R2", "to first", state_o, 2);
    chk("R2", "angle kept in blank", angle_o, 3);
    step(1'b1, 1'b0, 1'b1);
    chk("R2", "to synced", state_o, 3);
    chk("R2", "cleared at first tooth", angle_o, 0);
    ticks(4);
    step(1'b1, 1'b0, 1'b0);
    chk("R9", "synced state kept", state_o, 3);
    chk("R9", "synced angle kept", angle_o, 4);
    step(1'b1, 1'b0, 1'b1);
    chk("R9", "synced tooth+tick", angle_o, 5);
  endtask

  task automatic t_stall_low();
    to_synced();
    ticks(HALF - 1);
    cyc_len_i = W'(341);
    step(1'b0, 1'b1, 1'b1);
    chk("R4", "state after stall", state_o, 2);
    chk("R5", "angle cleared below half", angle_o, 0);
    chk("R7", "start loaded", cyc_start_o, 341);
    chk("R8", "reinit high", reinit_o, 1);
    cyc_len_i = W'(7);
    step(1'b0, 1'b0, 1'b1);
    chk("R8", "reinit one cycle", reinit_o, 0);
    chk("R7", "start kept", cyc_start_o, 341);
    step(1'b1, 1'b0, 1'b1);
    chk("R2", "tooth after stall clears", angle_o, 0);
    chk("R2", "synced after stall", state_o, 3);
  endtask

  task automatic t_stall_high();
    to_synced();
    ticks(HALF);
    cyc_len_i = W'(682);
    step(1'b0, 1'b1, 1'b1);
    chk("R6", "angle held at half", angle_o, HALF);
    chk("R4", "state after stall", state_o, 2);
    chk("R7", "start loaded", cyc_start_o, 682);
    ticks(2);
    chk("R3", "ticks continue", angle_o, HALF + 2);
    step(1'b1, 1'b0, 1'b0);
    chk("R2", "tooth clears high angle", angle_o, 0);
  endtask

  task automatic t_stall_tooth();
    do_reset();
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    ticks(2);
    step(1'b1, 1'b1, 1'b0);
    chk("R4", "stall beats tooth", state_o, 2);
    chk("R5", "angle cleared", angle_o, 0);
    chk("R8", "reinit", reinit_o, 1);
  endtask

  task automatic t_wrap();
    to_synced();
    ticks(FULL - 1);
    chk("R10", "top value", angle_o, FULL - 1);
    ticks(1);
    chk("R10", "wrapped", angle_o, 0);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    t_reset();
    t_sequence();
    t_stall_low();
    t_stall_high();
    t_stall_tooth();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule